// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a memory burst. A start strobe latches the first column and a mode word. The mode word sets the burst length and the wrap order. From the next clock on, the block presents one column per cycle, together with a valid flag. A last flag marks the closing beat of a fixed-length burst.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the start column, and the column bits above that block do not change. Within the block the beats follow one of two orders:
- Sequential: the low bits count upward and wrap around.
- Interleaved: the low bits are the start bits exclusive-ORed with the beat number.

A full-page burst walks upward through all 512 columns, wrapping from 511 to 0, until something ends it. A stop strobe ends any burst at once. So does a fresh start strobe, which also begins the new burst in the following cycle. Length codes that are not defined give a single beat and raise an error flag on that beat.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, and with no start strobe, valid, last and error outputs are all low.
- R2: A start strobe in cycle n makes valid high in cycle n+1, with the column equal to the start column latched in cycle n. Each following beat comes one clock later.
- R3: Mode bits [2:0] set the length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives full page.
- R4: With mode bit 3 at 0 (sequential), beat k carries the low bits (start + k) modulo the length. The bits above the length field equal the start column's bits (start 5, length 8: 5,6,7,0,1,2,3,4).
- R5: With mode bit 3 at 1 (interleaved), beat k carries the low bits start XOR k. The upper bits are unchanged (start 5, length 8: 5,4,7,6,1,0,3,2).
- R6: A full-page burst increments the column by one each cycle modulo 512 until it is stopped. Its last flag is never raised, and mode bit 3 has no effect on it.
- R7: The last flag is high only on the final beat of a fixed-length burst. Valid is low in the cycle after that beat unless a new start strobe arrived with it.
- R8: A stop strobe during a burst makes valid low in the next cycle. A stop strobe while idle has no effect. A stop strobe in the same cycle as a start strobe is overridden by the start.
- R9: A start strobe during a burst abandons the old burst, and the next cycle shows the first beat of the new one.
- R10: Length codes 100, 101 and 110 give a single beat with last high, and the error output is high on exactly that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a burst (read or write command seen) |
| start_col_i | input | 9 | First column of the burst |
| mode_i | input | 4 | Burst setting: [2:0] length code, [3] wrap order |
| stop_i | input | 1 | End the running burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | Current beat comes from a reserved length code |

## Verification
A wrong beat counter or a badly latched start column shows up on col_o in the first cycle where it is wrong. The address depends only on the registered state, so an error there cannot hide for a cycle. A corrupted length or an end-of-burst fault shows up within one cycle of the intended final beat, either as a misplaced last flag or as valid staying high or dropping early. The bench steps a behavioural model of the address list beside the block and compares every output on every cycle. Restarts, stops and full-page wraps are all covered by those per-cycle comparisons.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int COL_W    = 9;
    localparam int LCODE_W  = 3;
    localparam int MODE_W   = LCODE_W + 1;
    localparam int WRAP_BIT = LCODE_W;

    typedef enum logic {
        WRAP_SEQ = 1'b0,
        WRAP_ILV = 1'b1
    } wrap_e;

    typedef struct packed {
        logic [COL_W-1:0] mask;   // length - 1; all ones for full page
        logic             full;
        wrap_e            wrap;
        logic             bad;
    } burst_cfg_t;

    function automatic burst_cfg_t decode_mode(input logic [MODE_W-1:0] m);
        burst_cfg_t c;
        c.mask = '0;
        c.full = 1'b0;
        c.bad  = 1'b0;
        c.wrap = wrap_e'(m[WRAP_BIT]);
        case (m[LCODE_W-1:0])
            3'b000: c.mask = COL_W'(0);
            3'b001: c.mask = COL_W'(1);
            3'b010: c.mask = COL_W'(3);
            3'b011: c.mask = COL_W'(7);
            3'b111: begin
                c.mask = '1;
                c.full = 1'b1;
                c.wrap = WRAP_SEQ;
            end
            default: c.bad = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bcs_mode_decode.sv
module bcs_mode_decode
    import bcs_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output burst_cfg_t        cfg
);
    always_comb cfg = decode_mode(mode);
endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl
    import bcs_pkg::*;
#(
    parameter int CW = COL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic [CW-1:0] col_in,
    input  burst_cfg_t    cfg_in,
    output logic          active,
    output logic [CW-1:0] beat,
    output logic [CW-1:0] base,
    output burst_cfg_t    cfg_q,
    output logic          last
);
    logic [CW-1:0] beat_q;
    logic          act_q;

    assign last   = act_q && !cfg_q.full && (beat_q == cfg_q.mask);
    assign active = act_q;
    assign beat   = beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            beat_q <= '0;
            base   <= '0;
            cfg_q  <= '0;
        end else if (start) begin
            act_q  <= 1'b1;
            beat_q <= '0;
            base   <= col_in;
            cfg_q  <= cfg_in;
        end else if (act_q) begin
            if (stop || last) begin
                act_q <= 1'b0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int CW = COL_W
) (
    input  logic [CW-1:0] base,
    input  logic [CW-1:0] beat,
    input  burst_cfg_t    cfg,
    output logic [CW-1:0] col
);
    logic [CW-1:0] sum;
    assign sum = base + beat;

    for (genvar i = 0; i < CW; i++) begin : g_bit
        logic moving;
        assign moving = cfg.mask[i];
        assign col[i] = !moving ? base[i]
                      : (cfg.wrap == WRAP_ILV) ? (base[i] ^ beat[i])
                      : sum[i];
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              stop_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              last_o,
    output logic              err_o
);
    burst_cfg_t       cfg_new;
    burst_cfg_t       cfg_cur;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] base;
    logic             active;
    logic             last;

    bcs_mode_decode u_dec (
        .mode (mode_i),
        .cfg  (cfg_new)
    );

    bcs_beat_ctrl #(.CW(COL_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start_i),
        .stop   (stop_i),
        .col_in (start_col_i),
        .cfg_in (cfg_new),
        .active (active),
        .beat   (beat),
        .base   (base),
        .cfg_q  (cfg_cur),
        .last   (last)
    );

    bcs_addr_gen #(.CW(COL_W)) u_addr (
        .base (base),
        .beat (beat),
        .cfg  (cfg_cur),
        .col  (col_o)
    );

    assign valid_o = active;
    assign last_o  = last;
    assign err_o   = active && cfg_cur.bad;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
    import bcs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [COL_W-1:0]  start_col_i,
    input logic              stop_i,
    input logic [COL_W-1:0]  col_o,
    input logic              valid_o,
    input logic              last_o,
    input logic              err_o
);
    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    // R2
    beat_continue_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !stop_i && !start_i) |=> valid_o);

    // R7
    end_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && last_o && !start_i) |=> !valid_o);

    // R7
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    // R8
    stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && stop_i && !start_i) |=> !valid_o);

    // R8
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && !start_i) |=> !valid_o);

    // R10
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> last_o);
endmodule

bind burst_col_seq bcs_checker u_chk (.*);

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [3:0] mode_i = '0;
    logic       stop_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o, last_o, err_o;

    burst_col_seq uut (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .mode_i(mode_i), .stop_i(stop_i), .col_o(col_o), .valid_o(valid_o),
        .last_o(last_o), .err_o(err_o)
    );

    always #4 clk = ~clk;

    int    errors = 0;
    int    checks = 0;
    string req = "R1";
    bit    finished = 0;

    // reference model
    int q[$];
    bit fp_on  = 0;
    int fp_col = 0;
    bit m_err  = 0;

    task automatic compare();
        bit ev, el, ee;
        int ec;
        ev = fp_on || (q.size() > 0);
        ec = fp_on ? fp_col : (q.size() > 0 ? q[0] : 0);
        el = !fp_on && (q.size() == 1);
        ee = ev && m_err;
        checks++;
        if (valid_o !== ev || last_o !== el || err_o !== ee || (ev && col_o !== ec[8:0])) begin
            errors++;
            $display("FAIL %s: got valid=%0b col=%0d last=%0b err=%0b, expected valid=%0b col=%0d last=%0b err=%0b",
                     req, valid_o, col_o, last_o, err_o, ev, ec, el, ee);
        end
    endtask

    task automatic model(input bit s, input int c, input int m, input bit p);
        if (s) begin
            int len;
            bit ilv;
            q.delete();
            fp_on = 0;
            m_err = 0;
            ilv = m[3];
            case (m & 7)
                0: len = 1;
                1: len = 2;
                2: len = 4;
                3: len = 8;
                7: len = 0;
                default: begin len = 1; m_err = 1; end
            endcase
            if (len == 0) begin
                fp_on = 1;
                fp_col = c;
            end else begin
                int off, blk;
                off = c % len;
                blk = c - off;
                for (int k = 0; k < len; k++)
                    q.push_back(ilv ? blk + (off ^ k) : blk + ((off + k) % len));
            end
        end else if (fp_on) begin
            if (p) fp_on = 0;
            else   fp_col = (fp_col + 1) % 512;
        end else if (q.size() > 0) begin
            if (p) q.delete();
            else   void'(q.pop_front());
        end
    endtask

    task automatic cyc(input bit s, input int c, input int m, input bit p);
        @(negedge clk);
        compare();
        start_i = s; start_col_i = c[8:0]; mode_i = m[3:0]; stop_i = p;
        @(posedge clk);
        model(s, c, m, p);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    task automatic burst(input int c, input int m, input int after);
        cyc(1, c, m, 0);
        idle(after);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        req = "R1";
        idle(3);

        req = "R4";  burst(5, 4'b0011, 10);
        req = "R5";  burst(5, 4'b1011, 10);
        req = "R3";  burst(9'h1AB, 4'b0000, 3);
        req = "R3";  burst(9'h1AB, 4'b0001, 3);
        req = "R3";  burst(9'h1AB, 4'b0010, 5);
        req = "R5";  burst(9'h1AB, 4'b1001, 3);
        req = "R5";  burst(9'h1AE, 4'b1010, 5);
        req = "R4";  burst(9'h0FE, 4'b0011, 10);
        req = "R2";  burst(9'h1FF, 4'b0001, 3);

        req = "R6";
        cyc(1, 508, 4'b0111, 0);
        idle(9);
        cyc(0, 0, 0, 1);
        idle(3);
        req = "R6";
        cyc(1, 300, 4'b1111, 0);
        idle(6);
        cyc(0, 0, 0, 1);
        idle(2);

        req = "R8";
        cyc(1, 16, 4'b0011, 0);
        idle(2);
        cyc(0, 0, 0, 1);
        idle(3);
        cyc(0, 0, 0, 1);
        idle(2);
        cyc(1, 40, 4'b1010, 1);
        idle(6);

        req = "R9";
        cyc(1, 64, 4'b0011, 0);
        idle(3);
        cyc(1, 130, 4'b1011, 0);
        idle(2);
        cyc(1, 200, 4'b0111, 0);
        idle(4);
        cyc(1, 7, 4'b0010, 0);
        idle(6);

        req = "R7";
        cyc(1, 3, 4'b0001, 0);
        cyc(0, 0, 0, 0);
        cyc(1, 22, 4'b0001, 0);
        idle(4);

        req = "R10";
        burst(77, 4'b0100, 3);
        burst(78, 4'b1101, 3);
        burst(79, 4'b0110, 3);
        cyc(1, 80, 4'b0110, 0);
        cyc(1, 81, 4'b0011, 0);
        idle(10);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL %s: watchdog expired, got running, expected finished", req);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule